// File: doc/BRIEF.md
# Bridge Secondary Error Status Register

This block holds the 16-bit secondary-side error status word of a virtual PCI-to-PCI bridge placed in front of a serial graphics link. It watches upstream packet events that an external parser has already decoded. These events are posted-write headers and read-data completions with their poison flag, completion status codes for requests, and received fatal or non-fatal error messages. From them it latches five sticky status flags.

Two of the flags are gated by enable bits taken from the bridge-control register. Software clears a flag by writing 1 to it through a small synchronous register port. The port has a select, a write strobe, byte enables, write data and registered read data. The legacy parallel-bus fields of the word are fixed at zero.

Top module: `bridge_sec_err_status`

## Requirements
- R1: While reset is asserted and right after it is released, the status word reads 16'h0000 and `reg_rdata` is 16'h0000.
- R2: Bit 15 becomes 1 one clock after `pw_hdr_valid` and `pw_poisoned` are both 1. A poison flag without `pw_hdr_valid`, or a posted write without poison, leaves the bit unchanged.
- R3: Bit 14 becomes 1 after `err_msg_valid` is 1 while `ctl_serr_en` is 1. With `ctl_serr_en` at 0 the message has no effect.
- R4: Bit 13 becomes 1 after `cpl_valid` is 1 with `cpl_status` = 3'b001 (unsupported request) and `cpl_own` = 1. Other status codes do not set it.
- R5: Bit 12 becomes 1 after `cpl_valid` is 1 with `cpl_status` = 3'b100 (completer abort) and `cpl_own` = 1.
- R6: A completion with `cpl_own` = 0 is a forwarded completion and sets neither bit 13 nor bit 12.
- R7: Bit 8 becomes 1 after `rdc_valid` and `rdc_poisoned` are both 1 while `ctl_perr_en` is 1. With `ctl_perr_en` at 0, or an unpoisoned completion, the bit is unchanged.
- R8: A write (`reg_sel`=1, `reg_wr`=1) clears each sticky bit (15, 14, 13, 12, 8) whose `reg_wdata` bit is 1 and whose byte lane is enabled. Bits 15:8 are lane `reg_be[1]` and bits 7:0 are lane `reg_be[0]`. Data bits at 0, or a disabled lane, leave the bit unchanged.
- R9: When a set event and a clearing write hit the same bit in the same cycle, the bit ends at 1.
- R10: Bits 11, 10:9, 7, 6, 5 and 4:0 always read 0, including after writes of 1 to them.
- R11: A read (`reg_sel`=1, `reg_wr`=0) loads `reg_rdata` at that clock edge with the status word as it was before the edge. In every other cycle `reg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pw_hdr_valid | input | 1 | Upstream posted-write header seen this cycle |
| pw_poisoned | input | 1 | Poison flag of that posted write |
| rdc_valid | input | 1 | Upstream read-data completion seen this cycle |
| rdc_poisoned | input | 1 | Poison flag of that completion |
| cpl_valid | input | 1 | Completion status event this cycle |
| cpl_status | input | 3 | Completion status code (3'b001 unsupported request, 3'b100 completer abort) |
| cpl_own | input | 1 | Requester-ID match: completion answers a request the bridge issued |
| err_msg_valid | input | 1 | Fatal or non-fatal error message received from the secondary side |
| ctl_serr_en | input | 1 | System-error enable from bridge control |
| ctl_perr_en | input | 1 | Parity-error response enable from bridge control |
| reg_sel | input | 1 | Register address decode hit |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_be | input | 2 | Byte enables for writes |
| reg_wdata | input | 16 | Write data, 1 clears a sticky bit |
| reg_rdata | output | 16 | Registered read data |

## Verification
A hardware set event and a software write-1-to-clear can land on the same flag in one cycle. The bench provokes this by driving a poisoned posted write together with a write of 1 to bits 15 and 14 while both flags are already set. Only bit 15 has a live set event, so a following read must show bit 15 kept and bit 14 cleared. A second overlap checks that a write cycle does not disturb the held read data while events keep changing the word underneath.

// File: rtl/bses_pkg.sv
package bses_pkg;
  localparam int REG_W      = 16;
  localparam int CPL_STAT_W = 3;

  localparam int POS_PW_POISON = 15;
  localparam int POS_ERR_MSG   = 14;
  localparam int POS_CPL_UR    = 13;
  localparam int POS_CPL_CA    = 12;
  localparam int POS_RD_POISON = 8;

  localparam logic [REG_W-1:0] STICKY_MASK =
    (REG_W'(1) << POS_PW_POISON) | (REG_W'(1) << POS_ERR_MSG) |
    (REG_W'(1) << POS_CPL_UR)    | (REG_W'(1) << POS_CPL_CA)  |
    (REG_W'(1) << POS_RD_POISON);

  localparam logic [CPL_STAT_W-1:0] CPL_CODE_UR = 3'b001;
  localparam logic [CPL_STAT_W-1:0] CPL_CODE_CA = 3'b100;

  typedef struct packed {
    logic pw_poison;
    logic err_msg;
    logic cpl_ur;
    logic cpl_ca;
    logic rd_poison;
  } sts_set_t;
endpackage

// File: rtl/bses_event_decode.sv
module bses_event_decode
  import bses_pkg::*;
#(
  parameter int STAT_W = CPL_STAT_W,
  parameter logic [STAT_W-1:0] UR_CODE = CPL_CODE_UR,
  parameter logic [STAT_W-1:0] CA_CODE = CPL_CODE_CA
) (
  input  logic              pw_hdr_valid,
  input  logic              pw_poisoned,
  input  logic              rdc_valid,
  input  logic              rdc_poisoned,
  input  logic              cpl_valid,
  input  logic [STAT_W-1:0] cpl_status,
  input  logic              cpl_own,
  input  logic              err_msg_valid,
  input  logic              ctl_serr_en,
  input  logic              ctl_perr_en,
  output sts_set_t          set_o
);
  logic own_cpl;

  always_comb begin
    own_cpl         = cpl_valid & cpl_own;
    set_o.pw_poison = pw_hdr_valid & pw_poisoned;
    set_o.rd_poison = rdc_valid & rdc_poisoned & ctl_perr_en;
    set_o.err_msg   = err_msg_valid & ctl_serr_en;
    set_o.cpl_ur    = own_cpl & (cpl_status == UR_CODE);
    set_o.cpl_ca    = own_cpl & (cpl_status == CA_CODE);
  end
endmodule

// File: rtl/bses_sticky_bit.sv
module bses_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o)); // R8
endmodule

// File: rtl/bses_read_port.sv
module bses_read_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_sel,
  input  logic [W-1:0] image_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] rdata_d;

  always_comb begin
    rdata_d = image_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_o <= '0;
    else if (rd_sel) rdata_o <= rdata_d;
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |=> $stable(rdata_o)); // R11

  AST_RDATA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> (rdata_o == $past(image_i))); // R11
endmodule

// File: rtl/bridge_sec_err_status.sv
module bridge_sec_err_status
  import bses_pkg::*;
#(
  parameter int REG_W_P  = REG_W,
  parameter int STAT_W_P = CPL_STAT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pw_hdr_valid,
  input  logic                pw_poisoned,
  input  logic                rdc_valid,
  input  logic                rdc_poisoned,
  input  logic                cpl_valid,
  input  logic [STAT_W_P-1:0] cpl_status,
  input  logic                cpl_own,
  input  logic                err_msg_valid,
  input  logic                ctl_serr_en,
  input  logic                ctl_perr_en,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [REG_W_P/8-1:0] reg_be,
  input  logic [REG_W_P-1:0]  reg_wdata,
  output logic [REG_W_P-1:0]  reg_rdata
);
  localparam int BE_W = REG_W_P / 8;

  sts_set_t             set_ev;
  logic [REG_W_P-1:0]   set_vec;
  logic [REG_W_P-1:0]   clr_vec;
  logic [REG_W_P-1:0]   sts_q;
  logic                 wr_hit;
  logic                 rd_hit;

  bses_event_decode #(.STAT_W(STAT_W_P)) u_decode (
    .pw_hdr_valid (pw_hdr_valid),
    .pw_poisoned  (pw_poisoned),
    .rdc_valid    (rdc_valid),
    .rdc_poisoned (rdc_poisoned),
    .cpl_valid    (cpl_valid),
    .cpl_status   (cpl_status),
    .cpl_own      (cpl_own),
    .err_msg_valid(err_msg_valid),
    .ctl_serr_en  (ctl_serr_en),
    .ctl_perr_en  (ctl_perr_en),
    .set_o        (set_ev)
  );

  always_comb begin
    wr_hit  = reg_sel & reg_wr;
    rd_hit  = reg_sel & ~reg_wr;
    set_vec = '0;
    set_vec[POS_PW_POISON] = set_ev.pw_poison;
    set_vec[POS_ERR_MSG]   = set_ev.err_msg;
    set_vec[POS_CPL_UR]    = set_ev.cpl_ur;
    set_vec[POS_CPL_CA]    = set_ev.cpl_ca;
    set_vec[POS_RD_POISON] = set_ev.rd_poison;
    for (int i = 0; i < REG_W_P; i++) begin
      clr_vec[i] = wr_hit & reg_be[i/8] & reg_wdata[i];
    end
  end

  for (genvar g = 0; g < REG_W_P; g++) begin : g_bit
    if (STICKY_MASK[g]) begin : g_sticky
      bses_sticky_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_vec[g]),
        .clr_i(clr_vec[g]),
        .q_o  (sts_q[g])
      );
    end else begin : g_zero
      assign sts_q[g] = 1'b0;
    end
  end

  bses_read_port #(.W(REG_W_P)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_sel (rd_hit),
    .image_i(sts_q),
    .rdata_o(reg_rdata)
  );

  AST_PW_POISON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_hdr_valid && pw_poisoned) |=> sts_q[POS_PW_POISON]); // R2

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q[POS_ERR_MSG] && !(err_msg_valid && ctl_serr_en))
      |=> !sts_q[POS_ERR_MSG]); // R3

  AST_UR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_own && cpl_status == CPL_CODE_UR) |=> sts_q[POS_CPL_UR]); // R4

  AST_CA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_own && cpl_status == CPL_CODE_CA) |=> sts_q[POS_CPL_CA]); // R5

  AST_FWD_CPL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q[POS_CPL_UR] && !sts_q[POS_CPL_CA] && !(cpl_valid && cpl_own))
      |=> (!sts_q[POS_CPL_UR] && !sts_q[POS_CPL_CA])); // R6

  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q[POS_RD_POISON] && !(rdc_valid && rdc_poisoned && ctl_perr_en))
      |=> !sts_q[POS_RD_POISON]); // R7

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~STICKY_MASK) == '0); // R10
endmodule

// File: tb/bridge_sec_err_status_test.sv
module bridge_sec_err_status_test;
  logic        clk;
  logic        rst_n;
  logic        pw_hdr_valid, pw_poisoned, rdc_valid, rdc_poisoned;
  logic        cpl_valid, cpl_own, err_msg_valid, ctl_serr_en, ctl_perr_en;
  logic [2:0]  cpl_status;
  logic        reg_sel, reg_wr;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int n_run;
  int n_fail;
  bit done;

  bridge_sec_err_status uut (
    .clk(clk), .rst_n(rst_n),
    .pw_hdr_valid(pw_hdr_valid), .pw_poisoned(pw_poisoned),
    .rdc_valid(rdc_valid), .rdc_poisoned(rdc_poisoned),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_own(cpl_own),
    .err_msg_valid(err_msg_valid), .ctl_serr_en(ctl_serr_en),
    .ctl_perr_en(ctl_perr_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        serr;
    logic        perr;
    logic        pw_v;
    logic        pw_p;
    logic        rd_v;
    logic        rd_p;
    logic        cpl_v;
    logic [2:0]  cpl_s;
    logic        own;
    logic        err;
    logic        wr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0000,4'd2},  // R2 clean write
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'h8000,4'd2},  // R2 poisoned
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,2'b00,16'h0000,16'h8000,4'd3},  // R3 gated off
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,1'b0,2'b00,16'h0000,16'hC000,4'd3},  // R3 enabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,2'b00,16'h0000,16'hC000,4'd6},  // R6 fwd UR
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b1,1'b0,1'b0,2'b00,16'h0000,16'hE000,4'd4},  // R4 own UR
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,1'b0,1'b0,1'b0,2'b00,16'h0000,16'hE000,4'd6},  // R6 fwd CA
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,1'b1,1'b0,1'b0,2'b00,16'h0000,16'hF000,4'd5},  // R5 own CA
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'hF000,4'd7},  // R7 gated off
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'hF100,4'd7},  // R7 enabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,2'b11,16'h0000,16'hF100,4'd8},  // R8 zeros
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,2'b01,16'hFFFF,16'hF100,4'd8},  // R8 lane off
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,2'b10,16'h8000,16'h7100,4'd8},  // R8 one bit
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,2'b11,16'h0EFF,16'h7100,4'd10}, // R10 fixed bits
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b1,2'b11,16'hFFFF,16'h0000,4'd8},  // R8 all
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd2,1'b1,1'b0,1'b0,2'b00,16'h0000,16'h0000,4'd4},  // R4 other code
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0000,4'd7},  // R7 unpoisoned
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0000,4'd2}   // R2 no valid
  };

  task automatic idle_inputs();
    pw_hdr_valid = 0; pw_poisoned = 0; rdc_valid = 0; rdc_poisoned = 0;
    cpl_valid = 0; cpl_status = 3'd0; cpl_own = 0; err_msg_valid = 0;
    ctl_serr_en = 0; ctl_perr_en = 0; reg_sel = 0; reg_wr = 0;
    reg_be = 2'b00; reg_wdata = 16'h0000;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input vec_t v);
    ctl_serr_en = v.serr; ctl_perr_en = v.perr;
    pw_hdr_valid = v.pw_v; pw_poisoned = v.pw_p;
    rdc_valid = v.rd_v; rdc_poisoned = v.rd_p;
    cpl_valid = v.cpl_v; cpl_status = v.cpl_s; cpl_own = v.own;
    err_msg_valid = v.err;
    reg_sel = v.wr; reg_wr = v.wr; reg_be = v.be; reg_wdata = v.wd;
    tick();
    idle_inputs();
  endtask

  task automatic read_reg(output logic [15:0] val);
    reg_sel = 1; reg_wr = 0;
    tick();
    reg_sel = 0;
    val = reg_rdata;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    n_run = 0; n_fail = 0; done = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", reg_rdata, 16'h0000);
    rst_n = 1;
    tick();
    read_reg(rv);
    check("R1 word after reset", rv, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      read_reg(rv);
      check($sformatf("R%0d vector %0d", VECS[i].rq, i), rv, VECS[i].exp);
    end

    // R9: set event and write-1-to-clear on the same flag in one cycle
    pw_hdr_valid = 1; pw_poisoned = 1; err_msg_valid = 1; ctl_serr_en = 1;
    tick();
    idle_inputs();
    pw_hdr_valid = 1; pw_poisoned = 1;
    reg_sel = 1; reg_wr = 1; reg_be = 2'b10; reg_wdata = 16'hC000;
    tick();
    idle_inputs();
    read_reg(rv);
    check("R9 set beats clear", rv, 16'h8000);

    // R11: rdata holds across idle cycles, events and writes
    cpl_valid = 1; cpl_status = 3'b001; cpl_own = 1;
    tick();
    idle_inputs();
    check("R11 hold after event", reg_rdata, 16'h8000);
    reg_sel = 1; reg_wr = 1; reg_be = 2'b11; reg_wdata = 16'h0000;
    tick();
    idle_inputs();
    check("R11 hold over write", reg_rdata, 16'h8000);
    read_reg(rv);
    check("R11 fresh read", rv, 16'hA000);

    // R11: read returns the word as it was before a same-cycle event
    ctl_perr_en = 1; rdc_valid = 1; rdc_poisoned = 1;
    reg_sel = 1; reg_wr = 0;
    tick();
    idle_inputs();
    check("R11 pre-edge value", reg_rdata, 16'hA000);
    read_reg(rv);
    check("R7 set alongside read", rv, 16'hA100);

    // R1: reset in the middle of operation
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 async clear of rdata", reg_rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    tick();
    read_reg(rv);
    check("R1 word after second reset", rv, 16'h0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule